// File: doc/BRIEF.md
# Two-Level Segment Table Walker

This block resolves a translation-buffer miss for a paged memory system whose page table is split into segments. A virtual page number arrives with the type of access (read or write). The upper field of that number selects a word in a segment table, and the lower field selects a word in the page-table segment that the first word points to. The walker reads the segment word first. When that word is marked present, the walker reads the page word from the address it gives. It then hands the page word to the translation buffer, or it raises a fault that carries the page number and the reason for the fault.

Sparse address spaces are expected, so most segment words are absent. An absent segment word is therefore a normal outcome. It ends the walk after one read and causes no second memory access. Both reads use a simple request/valid port. The walker holds the request and the address steady until the memory returns data.

Virtual address layout, high to low: segment number (10 bits), page-in-segment (10 bits), offset (12 bits). The walker takes only the upper 20 bits as `req_vpn`. Segment word: bit 0 is present, and bits [31:2] are the word address of the page-table segment. Page word: bits [31:12] are the frame, bit 1 allows writes, and bit 0 is valid.

Top module: `seg_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req`, `done` and `fault` are 0.
- R2: One cycle after a request is accepted, `mem_req` rises with `mem_addr` = `table_base` + 4 × segment number (`req_vpn[19:10]`). The request and the address stay unchanged until the cycle in which `mem_rvalid` is 1.
- R3: When the segment word has bit 0 set, the next cycle issues a read at {segword[31:2],2'b00} + 4 × page-in-segment (`req_vpn[9:0]`). This read is held in the same way as the first.
- R4: When the segment word has bit 0 clear, the next cycle pulses `fault` with `fault_invalid`=1 and `fault_illegal`=0. No second read is issued.
- R5: A page word that is valid and permitted gives a `done` pulse in the cycle after its data arrives, with `res_frame`=word[31:12], `res_write`=word[1] and `res_valid`=1.
- R6: A page word with bit 0 clear gives a `fault` with `fault_invalid`=1.
- R7: A write request (`req_write`=1) whose page word has bit 1 clear gives a `fault` with `fault_illegal`=1. This is independent of `fault_invalid`. A read is never illegal.
- R8: During a fault, `fault_page` equals the 20-bit page number of the walk. Outside a fault, `fault_page` and both fault flags are 0.
- R9: While the walker is busy (`req_ready`=0), `req_valid` is ignored. While it is idle, `mem_rvalid` is ignored.
- R10: `done` and `fault` last one cycle and never occur together. `req_ready` returns the next cycle. The result outputs are 0 whenever `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vpn | input | 20 | Virtual page number (segment, page-in-segment) |
| req_write | input | 1 | Access is a write |
| table_base | input | 32 | Segment table base address |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Walk result pulse |
| res_frame | output | 20 | Frame number |
| res_write | output | 1 | Write permission |
| res_valid | output | 1 | Entry valid |
| fault | output | 1 | Fault pulse |
| fault_page | output | 20 | Faulting page number |
| fault_illegal | output | 1 | Write to a write-protected page |
| fault_invalid | output | 1 | Absent segment or page |

## Verification
A wrong state shows within one cycle. A stray second read after an absent segment word raises `mem_req` where the fault pulse belongs. A lost or early data capture moves `mem_addr` or `done` off the cycle the memory handshake fixes. A corrupted held entry shows as a wrong page address, a wrong frame or a wrong fault flag on the very next pulse. The bench varies memory latency from zero to three wait cycles and checks address stability in every wait cycle, so a request that is dropped early or advanced too soon is caught in the first cycle it goes wrong.

// File: rtl/seg_walker.sv
module seg_walker #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 10,
  parameter int PG_W   = 10,
  parameter int OFF_W  = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [SEG_W+PG_W-1:0]     req_vpn,
  input  logic                      req_write,
  input  logic [ADDR_W-1:0]         table_base,
  output logic                      mem_req,
  output logic [ADDR_W-1:0]         mem_addr,
  input  logic                      mem_rvalid,
  input  logic [ADDR_W-1:0]         mem_rdata,
  output logic                      done,
  output logic [ADDR_W-OFF_W-1:0]   res_frame,
  output logic                      res_write,
  output logic                      res_valid,
  output logic                      fault,
  output logic [SEG_W+PG_W-1:0]     fault_page,
  output logic                      fault_illegal,
  output logic                      fault_invalid
);
  localparam int PN_W = SEG_W + PG_W;

  typedef enum logic [1:0] {S_IDLE, S_SEG, S_PTE, S_FIN} st_t;

  st_t               st;
  logic [PN_W-1:0]   vpn_q;
  logic              wr_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] ent_q;
  logic              seg_bad_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      vpn_q     <= '0;
      wr_q      <= 1'b0;
      base_q    <= '0;
      ent_q     <= '0;
      seg_bad_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          vpn_q  <= req_vpn;
          wr_q   <= req_write;
          base_q <= table_base;
          st     <= S_SEG;
        end
        S_SEG: if (mem_rvalid) begin
          ent_q     <= mem_rdata;
          seg_bad_q <= ~mem_rdata[0];
          st        <= mem_rdata[0] ? S_PTE : S_FIN;
        end
        S_PTE: if (mem_rvalid) begin
          ent_q <= mem_rdata;
          st    <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [SEG_W-1:0]  seg_n;
  logic [PG_W-1:0]   pg_n;
  logic [ADDR_W-1:0] seg_addr, pte_addr;
  logic              bad_inv, bad_ill, fin, ok;

  assign seg_n    = vpn_q[PN_W-1 -: SEG_W];
  assign pg_n     = vpn_q[PG_W-1:0];
  assign seg_addr = base_q + (ADDR_W'(seg_n) << 2);
  assign pte_addr = {ent_q[ADDR_W-1:2], 2'b00} + (ADDR_W'(pg_n) << 2);

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st == S_SEG) || (st == S_PTE);
  assign mem_addr  = (st == S_SEG) ? seg_addr :
                     (st == S_PTE) ? pte_addr : '0;

  assign bad_inv = seg_bad_q | ~ent_q[0];
  assign bad_ill = ~seg_bad_q & wr_q & ~ent_q[1];
  assign fin     = (st == S_FIN);
  assign ok      = ~bad_inv & ~bad_ill;

  assign done      = fin & ok;
  assign fault     = fin & ~ok;
  assign res_frame = done ? ent_q[ADDR_W-1:OFF_W] : '0;
  assign res_write = done & ent_q[1];
  assign res_valid = done & ent_q[0];

  assign fault_page    = fault ? vpn_q : '0;
  assign fault_invalid = fault & bad_inv;
  assign fault_illegal = fault & bad_ill;
endmodule

module seg_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 10,
  parameter int PG_W   = 10,
  parameter int OFF_W  = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_ready,
  input logic                    mem_req,
  input logic [ADDR_W-1:0]       mem_addr,
  input logic                    mem_rvalid,
  input logic                    done,
  input logic [ADDR_W-OFF_W-1:0] res_frame,
  input logic                    res_write,
  input logic                    res_valid,
  input logic                    fault,
  input logic [SEG_W+PG_W-1:0]   fault_page,
  input logic                    fault_illegal,
  input logic                    fault_invalid
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req && !done && !fault);

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, mem_req, done, fault}));

  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> req_ready);

  p_after_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> $past(mem_req && mem_rvalid));

  p_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_valid);

  p_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_invalid || fault_illegal));

  p_res_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (res_frame == '0 && !res_write && !res_valid));

  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> (fault_page == '0 && !fault_illegal && !fault_invalid));
endmodule

bind seg_walker seg_walker_chk #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .PG_W(PG_W), .OFF_W(OFF_W)) i_chk (.*);

// File: tb/test_seg_walker.sv
module test_seg_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_vpn = '0;
  logic        req_write = 1'b0;
  logic [31:0] table_base = 32'h0010_0000;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic [19:0] res_frame;
  logic        res_write, res_valid, fault;
  logic [19:0] fault_page;
  logic        fault_illegal, fault_invalid;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  seg_walker i_seg_walker (.*);

  // vector: va[98:67] write[66] segword[65:34] pteword[33:2] latency[1:0]
  localparam int NV = 8;
  localparam logic [98:0] VEC [NV] = '{
    {32'h0040_1ABC, 1'b0, 32'h0020_0001, 32'h0ABC_D003, 2'd0},
    {32'hFFC0_0123, 1'b1, 32'h0030_0005, 32'h1234_5001, 2'd1},
    {32'h003F_F000, 1'b0, 32'h0000_8001, 32'h0000_0000, 2'd3},
    {32'h1234_5678, 1'b1, 32'hDEAD_BEE0, 32'hFFFF_FFFF, 2'd2},
    {32'h8000_1000, 1'b1, 32'h0001_0001, 32'hFFFF_F002, 2'd0},
    {32'h0050_2000, 1'b1, 32'h0002_0003, 32'h7777_7000, 2'd1},
    {32'hABCD_E000, 1'b0, 32'h00F0_0001, 32'h5555_5001, 2'd2},
    {32'h7FFF_F000, 1'b1, 32'h0000_0401, 32'h0000_1003, 2'd0}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input bit wr, input logic [31:0] sw,
                      input logic [31:0] pw, input int lat);
    logic [31:0] a_seg, a_pte;
    bit exp_inv, exp_ill;
    a_seg = table_base + {20'd0, va[31:22], 2'b00};
    a_pte = {sw[31:2], 2'b00} + {20'd0, va[21:12], 2'b00};
    @(negedge clk);
    req_vpn = va[31:12]; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_req && mem_addr == a_seg, "R2 segment read address", {31'd0, mem_req, mem_addr}, {32'd1, a_seg});
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(mem_req && mem_addr == a_seg, "R2 segment read held", {31'd0, mem_req, mem_addr}, {32'd1, a_seg});
    end
    mem_rvalid = 1'b1; mem_rdata = sw;
    @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = '0;
    if (!sw[0]) begin
      chk(fault && fault_invalid && !fault_illegal && !mem_req, "R4 absent segment fault",
          {60'd0, fault, fault_invalid, fault_illegal, mem_req}, 64'b1100);
      chk(fault_page == va[31:12], "R8 fault page", fault_page, va[31:12]);
    end else begin
      chk(mem_req && mem_addr == a_pte, "R3 page read address", {31'd0, mem_req, mem_addr}, {32'd1, a_pte});
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk(mem_req && mem_addr == a_pte, "R3 page read held", {31'd0, mem_req, mem_addr}, {32'd1, a_pte});
      end
      mem_rvalid = 1'b1; mem_rdata = pw;
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rdata = '0;
      exp_inv = !pw[0];
      exp_ill = wr && !pw[1];
      if (!exp_inv && !exp_ill) begin
        chk(done && !fault && res_frame == pw[31:12] && res_write == pw[1] && res_valid,
            "R5 walk result", {done, fault, res_write, res_valid, 40'd0, res_frame},
            {1'b1, 1'b0, pw[1], 1'b1, 40'd0, pw[31:12]});
      end else begin
        chk(fault && !done && fault_invalid == exp_inv, "R6 invalid page flag",
            {61'd0, fault, done, fault_invalid}, {61'd0, 1'b1, 1'b0, exp_inv});
        chk(fault_illegal == exp_ill, "R7 illegal write flag", fault_illegal, exp_ill);
        chk(fault_page == va[31:12], "R8 fault page", fault_page, va[31:12]);
        chk(res_frame == '0 && !res_valid, "R10 result quiet on fault", res_frame, 0);
      end
    end
    @(negedge clk);
    chk(req_ready && !done && !fault && fault_page == '0, "R10 single pulse, back to ready",
        {61'd0, req_ready, done, fault}, 64'b100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req && !done && !fault, "R1 reset state",
        {60'd0, req_ready, mem_req, done, fault}, 64'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !mem_req, "R1 idle after reset", {62'd0, req_ready, mem_req}, 64'b10);

    // R9: read data while idle is ignored
    mem_rvalid = 1'b1; mem_rdata = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = '0;
    chk(req_ready && !mem_req && !done && !fault, "R9 idle ignores rvalid",
        {60'd0, req_ready, mem_req, done, fault}, 64'b1000);

    for (int v = 0; v < NV; v++)
      walk(VEC[v][98:67], VEC[v][66], VEC[v][65:34], VEC[v][33:2], int'(VEC[v][1:0]));

    // R9: a request while busy is ignored
    @(negedge clk);
    req_vpn = 20'h00C05; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    req_vpn = 20'hFFFFF; table_base = 32'h0900_0000;
    chk(mem_addr == 32'h0010_000C, "R9 busy start address", mem_addr, 32'h0010_000C);
    @(negedge clk);
    chk(mem_req && mem_addr == 32'h0010_000C, "R9 busy request ignored", mem_addr, 32'h0010_000C);
    req_valid = 1'b0;
    mem_rvalid = 1'b1; mem_rdata = 32'h0;
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk(fault && fault_page == 20'h00C05, "R9 busy walk keeps page", fault_page, 20'h00C05);
    @(negedge clk);
    table_base = 32'h0010_0000;
    chk(req_ready && !mem_req, "R9 no walk from busy request", {62'd0, req_ready, mem_req}, 64'b10);

    // R1: reset mid-walk returns to idle
    @(negedge clk);
    req_vpn = 20'h12345; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_req, "R1 reset aborts walk", {62'd0, req_ready, mem_req}, 64'b10);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule